// File: doc/BRIEF.md
# PWM Carrier Chopper

This block sits between a PWM generator and the output drivers and chops each of two PWM channels (A and B) with a high-frequency carrier. It is meant for driving gate transformers. A 4-bit prescaler divides the PWM clock into carrier ticks. Eight ticks make one carrier period. The carrier is high for a programmable number of those eight ticks.

When a channel's input goes active, the output first gives a solid pulse that lasts a programmable number of whole carrier periods. After that pulse, the chopped carrier follows for as long as the input stays active. Each channel has its own three-state controller: `ST_IDLE`, `ST_SHOT` and `ST_CHOP`. Each channel also has its own prescaler and phase counter, and these restart on every rising input edge, so the carrier phase always lines up with the input.

The transitions are named as follows. `start` goes from `ST_IDLE` to `ST_SHOT` when the shot width is not 0, and from `ST_IDLE` to `ST_CHOP` when it is 0. `shot_done` goes from `ST_SHOT` to `ST_CHOP` at the end of the last solid period. `drop` goes from `ST_SHOT` or `ST_CHOP` back to `ST_IDLE` when the input falls or the block is disabled.

When the enable input is low, both inputs pass through raw. Input inversion is applied ahead of edge detection. Output inversion is applied to the chopped result.

Top module: `pwm_chopper`

## Requirements
- R1: While `enable` is 0, each output equals its raw input in the same cycle. `in_invert` and `out_invert` have no effect in this mode.
- R2: While `enable` is 1 and a channel's effective input (the raw input XOR `in_invert`) is 0, that channel's output is `out_invert`. This is also the state directly after reset.
- R3: In the cycle where the effective input rises, the output is still inactive, that is, equal to `out_invert`. The cycle count m starts at 0 in the next cycle and increases by one each cycle while the input stays high. The output is solid active while the carrier period index, floor(m/(P+1))/8, is less than W.
- R4: After the solid pulse, the output is active exactly when the tick phase, floor(m/(P+1)) mod 8, is less than the duty value D.
- R5: One carrier tick lasts P+1 PWM clock cycles, where P is the value of `prescale` (0 to 15).
- R6: When W is 0, there is no solid pulse, and chopping starts in the first cycle after the rise.
- R7: When D is 0, the carrier is always low, so after any solid pulse the output stays inactive while the input is high.
- R8: A falling effective input makes the output inactive in the same cycle, during either the solid pulse or the chopping.
- R9: When `in_invert` is 1, a low raw input is treated as active, including for edge detection.
- R10: When `enable` is 1, `out_invert` complements both outputs.
- R11: P, D and W are captured at each rising edge. A change to them while the input is high takes effect only at the next rising edge.
- R12: Channels A and B keep separate one-shot and carrier timing, and they share only the configuration values.
- R13: If `enable` rises while an effective input is already high, that channel stays inactive until the input's next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | 1 = chopping active, 0 = raw bypass |
| in_invert | input | 1 | Complement both inputs before processing |
| out_invert | input | 1 | Complement both chopped outputs |
| prescale | input | 4 | Tick length minus one, in PWM clocks |
| duty | input | 3 | Carrier high ticks out of 8 |
| shot_width | input | 4 | Solid first pulse length in carrier periods |
| pwm_a_in | input | 1 | Channel A PWM input |
| pwm_b_in | input | 1 | Channel B PWM input |
| pwm_a_out | output | 1 | Channel A chopped output |
| pwm_b_out | output | 1 | Channel B chopped output |

## Verification
Directed patterns cover several single long pulses with known P, D and W. These tell the end of the solid pulse apart from the start of the carrier, and one tick length apart from another. Further directed patterns drop the input mid-pulse, change the configuration mid-pulse, and enable the block while an input is already high; these separate a correct edge capture and correct latching from level-based behaviour. A fixed-seed random phase then toggles the two inputs independently under randomly chosen configuration and inversion settings. This phase exposes any coupling between the channels and any phase error that only builds up over many periods. Every cycle is compared against a reference model kept in the bench.

// File: rtl/chop_pkg.sv
package chop_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SHOT = 2'd1,
        ST_CHOP = 2'd2
    } chop_state_e;

    localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/chop_timebase.sv
// Per-channel prescaler and carrier phase counter, restartable on an edge.
module chop_timebase #(
    parameter int unsigned PRE_W = 4,
    parameter int unsigned PH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [PRE_W-1:0] limit,
    output logic [PH_W-1:0]  phase,
    output logic             wrap
);
    logic [PRE_W-1:0] pre_q;
    logic [PH_W-1:0]  ph_q;
    logic             tick_last;

    assign tick_last = (pre_q == limit);
    assign wrap      = run && tick_last && (ph_q == {PH_W{1'b1}});
    assign phase     = ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            ph_q  <= '0;
        end else if (restart) begin
            pre_q <= '0;
            ph_q  <= '0;
        end else if (run) begin
            if (tick_last) begin
                pre_q <= '0;
                ph_q  <= ph_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/chop_channel.sv
// One chopper channel: edge capture, one-shot/chop state machine.
module chop_channel
    import chop_pkg::*;
#(
    parameter int unsigned PRE_W  = 4,
    parameter int unsigned DUTY_W = 3,
    parameter int unsigned SHOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              x,
    input  logic [PRE_W-1:0]  pre_cfg,
    input  logic [DUTY_W-1:0] duty_cfg,
    input  logic [SHOT_W-1:0] shot_cfg,
    output logic              core
);
    chop_state_e       state_q, state_d;
    logic              x_q;
    logic              start;
    logic [PRE_W-1:0]  pre_l;
    logic [DUTY_W-1:0] duty_l;
    logic [SHOT_W-1:0] shot_l;
    logic [SHOT_W-1:0] shot_cnt_q;
    logic [DUTY_W-1:0] phase;
    logic              wrap;
    logic              last_shot;

    assign start     = en && x && !x_q;
    assign last_shot = wrap && (shot_cnt_q == SHOT_W'(shot_l - 1'b1));

    chop_timebase #(.PRE_W(PRE_W), .PH_W(DUTY_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (state_q != ST_IDLE),
        .limit   (pre_l),
        .phase   (phase),
        .wrap    (wrap)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (shot_cfg != '0) ? ST_SHOT : ST_CHOP;
            ST_SHOT: begin
                if (!en || !x)      state_d = ST_IDLE;
                else if (last_shot) state_d = ST_CHOP;
            end
            ST_CHOP: if (!en || !x) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and per-edge captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            x_q        <= 1'b0;
            pre_l      <= '0;
            duty_l     <= '0;
            shot_l     <= '0;
            shot_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            x_q     <= x;
            if (start) begin
                pre_l      <= pre_cfg;
                duty_l     <= duty_cfg;
                shot_l     <= shot_cfg;
                shot_cnt_q <= '0;
            end else if (state_q == ST_SHOT && wrap) begin
                shot_cnt_q <= shot_cnt_q + 1'b1;
            end
        end
    end

    // output logic
    always_comb begin
        core = 1'b0;
        unique case (state_q)
            ST_IDLE: core = 1'b0;
            ST_SHOT: core = x;
            ST_CHOP: core = x && (phase < duty_l);
            default: core = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
    import chop_pkg::*;
#(
    parameter int unsigned PRE_W  = 4,
    parameter int unsigned DUTY_W = 3,
    parameter int unsigned SHOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              in_invert,
    input  logic              out_invert,
    input  logic [PRE_W-1:0]  prescale,
    input  logic [DUTY_W-1:0] duty,
    input  logic [SHOT_W-1:0] shot_width,
    input  logic              pwm_a_in,
    input  logic              pwm_b_in,
    output logic              pwm_a_out,
    output logic              pwm_b_out
);
    logic [NUM_CH-1:0] raw_in;
    logic [NUM_CH-1:0] eff_in;
    logic [NUM_CH-1:0] core;
    logic [NUM_CH-1:0] out_v;

    assign raw_in = {pwm_b_in, pwm_a_in};
    assign eff_in = raw_in ^ {NUM_CH{in_invert}};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        chop_channel #(.PRE_W(PRE_W), .DUTY_W(DUTY_W), .SHOT_W(SHOT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (enable),
            .x        (eff_in[g]),
            .pre_cfg  (prescale),
            .duty_cfg (duty),
            .shot_cfg (shot_width),
            .core     (core[g])
        );
        assign out_v[g] = enable ? (core[g] ^ out_invert) : raw_in[g];
    end

    assign pwm_a_out = out_v[0];
    assign pwm_b_out = out_v[1];
endmodule

// File: rtl/chop_chk.sv
module chop_chk #(
    parameter int unsigned DUTY_W = 3,
    parameter int unsigned SHOT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              in_invert,
    input logic              out_invert,
    input logic [DUTY_W-1:0] duty,
    input logic [SHOT_W-1:0] shot_width,
    input logic              pwm_a_in,
    input logic              pwm_b_in,
    input logic              pwm_a_out,
    input logic              pwm_b_out
);
    logic [1:0] rin, x, xp, o;
    assign rin = {pwm_b_in, pwm_a_in};
    assign o   = {pwm_b_out, pwm_a_out};
    assign x   = rin ^ {2{in_invert}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xp <= '0;
        else        xp <= x;
    end

    for (genvar i = 0; i < 2; i++) begin : g_chk
        // R1
        bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !enable |-> o[i] == rin[i]);
        // R2
        idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (enable && !x[i]) |-> o[i] == out_invert);
        // R3
        rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (enable && x[i] && !xp[i]) |-> o[i] == out_invert);
        // R3
        shot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (enable && x[i] && !xp[i] && shot_width != '0)
            |=> (!enable || !x[i] || o[i] == !out_invert));
        // R7
        zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (enable && x[i] && !xp[i] && shot_width == '0 && duty == '0)
            |=> (!enable || !x[i] || o[i] == out_invert));
    end
endmodule

bind pwm_chopper chop_chk #(.DUTY_W(DUTY_W), .SHOT_W(SHOT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .in_invert  (in_invert),
    .out_invert (out_invert),
    .duty       (duty),
    .shot_width (shot_width),
    .pwm_a_in   (pwm_a_in),
    .pwm_b_in   (pwm_b_in),
    .pwm_a_out  (pwm_a_out),
    .pwm_b_out  (pwm_b_out)
);

// File: tb/pwm_chopper_tb.sv
`timescale 1ns/1ps
module pwm_chopper_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, in_invert = 1'b0, out_invert = 1'b0;
    logic [3:0] prescale = '0;
    logic [2:0] duty = '0;
    logic [3:0] shot_width = '0;
    logic       a_in = 1'b0, b_in = 1'b0;
    logic       a_out, b_out;

    int checks = 0, fails = 0;
    string cur_tag = "R2";

    // reference model state per channel
    bit prev [2];
    bit act  [2];
    int m    [2];
    int lp   [2];
    int ld   [2];
    int lw   [2];

    always #2 clk = ~clk;

    pwm_chopper u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .in_invert(in_invert),
        .out_invert(out_invert), .prescale(prescale), .duty(duty),
        .shot_width(shot_width), .pwm_a_in(a_in), .pwm_b_in(b_in),
        .pwm_a_out(a_out), .pwm_b_out(b_out)
    );

    function automatic bit raw_of(int ch);
        return (ch == 0) ? a_in : b_in;
    endfunction

    function automatic bit exp_core(int ch);
        bit xv;
        int t;
        xv = raw_of(ch) ^ in_invert;
        if (!act[ch] || !xv) return 1'b0;
        t = m[ch] / (lp[ch] + 1);
        return ((t / 8) < lw[ch]) || ((t % 8) < ld[ch]);
    endfunction

    function automatic bit exp_out(int ch);
        return enable ? (exp_core(ch) ^ out_invert) : raw_of(ch);
    endfunction

    task automatic check_and_advance();
        bit xv, got, exp;
        for (int ch = 0; ch < 2; ch++) begin
            got = (ch == 0) ? a_out : b_out;
            exp = exp_out(ch);
            checks++;
            if (got !== exp) begin
                fails++;
                $display("FAIL %s ch%0d t=%0t actual=%b expected=%b", cur_tag, ch, $time, got, exp);
            end
        end
        for (int ch = 0; ch < 2; ch++) begin
            xv = raw_of(ch) ^ in_invert;
            if (!enable) act[ch] = 1'b0;
            else if (xv && !prev[ch]) begin
                act[ch] = 1'b1; m[ch] = 0;
                lp[ch] = int'(prescale); ld[ch] = int'(duty); lw[ch] = int'(shot_width);
            end else if (xv && act[ch]) m[ch]++;
            else act[ch] = 1'b0;
            prev[ch] = xv;
        end
    endtask

    task automatic cyc(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_and_advance();
            @(posedge clk);
            #1;
        end
    endtask

    task automatic cfg(bit e, bit ii, bit oi, int p, int d, int w);
        enable = e; in_invert = ii; out_invert = oi;
        prescale = 4'(p); duty = 3'(d); shot_width = 4'(w);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int ch = 0; ch < 2; ch++) begin
            prev[ch] = 0; act[ch] = 0; m[ch] = 0; lp[ch] = 0; ld[ch] = 0; lw[ch] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: reset state, enabled with idle inputs
        cur_tag = "R2"; cfg(1, 0, 0, 0, 4, 1); cyc(4);

        // R1: bypass ignores both inversions
        cur_tag = "R1"; cfg(0, 1, 1, 2, 3, 1);
        a_in = 1; b_in = 0; cyc(3); a_in = 0; b_in = 1; cyc(3); b_in = 0; cyc(2);

        // R3 / R5: P=1, D=3, W=1 long pulse
        cur_tag = "R3_R5"; cfg(1, 0, 0, 1, 3, 1);
        a_in = 1; cyc(60); a_in = 0; cyc(3);

        // R4 / R5: P=3, D=5, W=2
        cur_tag = "R4_R5"; cfg(1, 0, 0, 3, 5, 2);
        b_in = 1; cyc(120); b_in = 0; cyc(3);

        // R6: no solid pulse
        cur_tag = "R6"; cfg(1, 0, 0, 0, 5, 0);
        a_in = 1; cyc(30); a_in = 0; cyc(2);

        // R7: zero duty
        cur_tag = "R7"; cfg(1, 0, 0, 0, 0, 2);
        a_in = 1; b_in = 1; cyc(40); a_in = 0; b_in = 0; cyc(2);

        // R8: fall mid-shot and mid-chop
        cur_tag = "R8"; cfg(1, 0, 0, 1, 4, 3);
        a_in = 1; cyc(10); a_in = 0; cyc(3);
        a_in = 1; cyc(55); a_in = 0; cyc(3);

        // R9: input inversion
        cur_tag = "R9"; cfg(1, 1, 0, 0, 2, 1);
        a_in = 1; b_in = 1; cyc(3); a_in = 0; cyc(25); a_in = 1; b_in = 0; cyc(20); b_in = 1; cyc(2);

        // R10: output inversion
        cur_tag = "R10"; cfg(1, 0, 1, 0, 6, 1);
        a_in = 0; b_in = 0; cyc(3); a_in = 1; cyc(25); a_in = 0; cyc(3);

        // R11: config change mid-pulse is ignored until next rise
        cur_tag = "R11"; cfg(1, 0, 0, 0, 2, 1);
        a_in = 1; cyc(12); cfg(1, 0, 0, 2, 7, 3); cyc(30); a_in = 0; cyc(2);
        a_in = 1; cyc(80); a_in = 0; cyc(2);

        // R12: independent channels, staggered edges
        cur_tag = "R12"; cfg(1, 0, 0, 0, 3, 1);
        a_in = 1; cyc(5); b_in = 1; cyc(13); a_in = 0; cyc(4); a_in = 1; cyc(20);
        a_in = 0; b_in = 0; cyc(2);

        // R13: enable rises with input already high
        cur_tag = "R13"; cfg(0, 0, 0, 0, 4, 1);
        a_in = 1; cyc(3); enable = 1; cyc(15); a_in = 0; cyc(1); a_in = 1; cyc(15); a_in = 0; cyc(2);

        // R4 / R12: constrained random
        cur_tag = "R4_rand";
        for (int s = 0; s < 60; s++) begin
            cfg(($urandom % 10) != 0, $urandom % 2, $urandom % 2,
                (($urandom % 6) == 0) ? 15 : ($urandom % 4), $urandom % 8, $urandom % 4);
            for (int c = 0; c < 150; c++) begin
                if (($urandom % 20) == 0) a_in = ~a_in;
                if (($urandom % 25) == 0) b_in = ~b_in;
                if (($urandom % 200) == 0) duty = 3'($urandom % 8);
                cyc(1);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule